// File: doc/BRIEF.md
# Overlay Pixel Unpacker and Alpha Blender

This block is the per-pixel datapath of an on-screen overlay. Each beat carries one raw pixel container word taken from the overlay buffer, together with the video pixel it will be laid over. The block picks the pixel out of the container according to a container-size code and a colour-format code. It widens packed RGB formats to 8 bits per channel and resolves indexed pixels through a 256-entry colour table. It then works out an effective 8-bit opacity from three independently enabled sources: a colour-key match, per-pixel alpha and a single overlay-wide alpha.

Every beat produces three results: the overlay colour, the effective opacity, and the colour mixed over the video pixel. Beats enter and leave on valid/ready handshakes. The three pipeline stages advance together, so `in_ready` is high whenever the output register is empty or `out_ready` is high. A beat is taken on any edge where `in_valid` and `in_ready` are both high. While `out_valid` is high and `out_ready` is low, the output beat is held unchanged and no new beat is taken. The configuration pins are plain levels and are sampled with the beat.

Software loads the colour table in two steps. It first writes an 8-bit entry number to an index register. A later strobe on the data register then writes the 32-bit entry to the entry that the index register names.

Top module: `osd_pix_blend`

## Requirements
- R1: A beat is taken when `in_valid && in_ready`. `in_ready` is high whenever `out_valid` is low or `out_ready` is high. While `out_valid && !out_ready`, the outputs stay unchanged and `in_ready` is low.
- R2: With `out_ready` held high, a beat taken at edge n shows on the outputs, with `out_valid` high, after edge n+2. After edge n+1 the output register is still empty.
- R3: A container code `cfg_bpp` of 01 (8 bits) or 00 forces indexed format whatever `cfg_fmt` holds. Codes 10 and 11 select 16-bit and 32-bit containers.
- R4: A strobe on `pal_index_we` loads `pal_index` and changes no table entry. A strobe on `pal_data_we` writes `pal_data` into the entry the index register names. An entry holds alpha in bits 31:24, red in 23:16, green in 15:8 and blue in 7:0.
- R5: Format code 001 (565) takes red from bits 15:11, green from 10:5 and blue from 4:0. Each channel is widened by copying its top bits into the vacated low bits. 565 has no per-pixel alpha, so it counts as 255.
- R6: Format 010 (555) takes red from bits 14:10, green from 9:5 and blue from 4:0. Format 011 (444) takes red from 11:8, green from 7:4 and blue from 3:0, each widened by repetition. With `cfg_local_en` set, bit 15 set makes the per-pixel alpha 0 and bit 15 clear makes it 255.
- R7: Format 100 (and codes 101–111) is 8888: colour is in bits 23:0 and per-pixel alpha in bits 31:24. Indexed pixels use bits 7:0 and 16-bit formats use bits 15:0. All container bits above these are padding and have no effect.
- R8: For indexed pixels the per-pixel alpha is the table entry's alpha. Whenever `cfg_local_en` is low, the per-pixel alpha is 255 in every format.
- R9: With `cfg_key_en` set, a pixel whose key field equals `cfg_key` gets effective alpha 0. The key field is the index byte for indexed pixels (`cfg_key[7:0]`), the 16 low bits for the 16-bit formats (`cfg_key[15:0]`), and the 24 colour bits for 8888.
- R10: The effective alpha is (L × G + 127) / 255, rounded down. L is the per-pixel alpha. G is `cfg_global_alpha` when `cfg_global_en` is set and 255 otherwise.
- R11: Each 8-bit channel of `out_mix` is (osd × a + video × (255 − a) + 127) / 255. `in_video` holds red in 23:16, green in 15:8 and blue in 7:0.
- R12: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat can be taken |
| in_word | input | 32 | Raw pixel container |
| in_video | input | 24 | Video pixel under the overlay |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer can take the output beat |
| out_rgb | output | 24 | Overlay colour |
| out_alpha | output | 8 | Effective opacity |
| out_mix | output | 24 | Overlay blended over video |
| cfg_fmt | input | 3 | Colour-format code |
| cfg_bpp | input | 2 | Container-size code |
| cfg_local_en | input | 1 | Per-pixel alpha enable |
| cfg_global_en | input | 1 | Overlay-wide alpha enable |
| cfg_global_alpha | input | 8 | Overlay-wide alpha value |
| cfg_key_en | input | 1 | Colour-key enable |
| cfg_key | input | 24 | Colour-key value |
| pal_index_we | input | 1 | Table index register write strobe |
| pal_index | input | 8 | Table index value |
| pal_data_we | input | 1 | Table entry write strobe |
| pal_data | input | 32 | Table entry value |

## Verification
Each result is registered in the third stage, so a beat taken at edge n is checked at the falling edge after edge n+2. In the latency test, the output is also seen empty at the falling edge after edge n+1. Inputs are driven on falling edges and held through the accepting edge. The next beat is sent only after the previous result has been checked, so every sample lands in a known cycle.

The back-pressure test holds `out_ready` low for three extra edges while a second beat waits. It confirms that the first result does not move and that the waiting beat is taken only at the edge where `out_ready` returns. That beat is then checked two edges later. Table writes complete two edges before any beat that reads the entry.

// File: rtl/osd_pix_pkg.sv
package osd_pix_pkg;
  localparam int CH_W  = 8;
  localparam int RGB_W = 3 * CH_W;
  localparam int WORD_W = 32;
  localparam int ACC_W = 2 * CH_W + 1;

  typedef enum logic [2:0] {
    FMT_IDX8     = 3'd0,
    FMT_RGB565   = 3'd1,
    FMT_RGB555   = 3'd2,
    FMT_RGB444   = 3'd3,
    FMT_ARGB8888 = 3'd4
  } osd_fmt_e;

  typedef struct packed {
    logic [RGB_W-1:0] rgb;
    logic [CH_W-1:0]  alpha;
    logic             use_pal;
    logic             pal_alpha;
    logic [CH_W-1:0]  idx;
    logic             key_hit;
  } unpack_t;

  function automatic logic [CH_W-1:0] widen4(input logic [3:0] v);
    return {v, v};
  endfunction

  function automatic logic [CH_W-1:0] widen5(input logic [4:0] v);
    return {v, v[4:2]};
  endfunction

  function automatic logic [CH_W-1:0] widen6(input logic [5:0] v);
    return {v, v[5:4]};
  endfunction

  // rounded product of two 8-bit fractions of 255
  function automatic logic [CH_W-1:0] frac_mul(input logic [CH_W-1:0] x,
                                               input logic [CH_W-1:0] y);
    logic [ACC_W-1:0] acc;
    acc = ACC_W'(x) * ACC_W'(y) + ACC_W'(127);
    return CH_W'(acc / ACC_W'(255));
  endfunction
endpackage

// File: rtl/osd_palette.sv
module osd_palette #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idx_we,
  input  logic [AW-1:0] idx_in,
  input  logic          data_we,
  input  logic [DW-1:0] data_in,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [AW-1:0] idx_q;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else if (idx_we) idx_q <= idx_in;
  end

  always_ff @(posedge clk) begin
    if (data_we) mem[idx_q] <= data_in;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/osd_unpack.sv
module osd_unpack
  import osd_pix_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [2:0]        fmt_code,
  input  logic [1:0]        bpp_code,
  input  logic              local_en,
  input  logic              key_en,
  input  logic [RGB_W-1:0]  key,
  output unpack_t           u
);
  osd_fmt_e fmt;
  logic     switch_alpha;

  always_comb begin
    if (bpp_code == 2'b00 || bpp_code == 2'b01) fmt = FMT_IDX8;
    else if (fmt_code > 3'd4)                   fmt = FMT_ARGB8888;
    else                                        fmt = osd_fmt_e'(fmt_code);
  end

  assign switch_alpha = local_en && word[15];

  always_comb begin
    u = '0;
    u.alpha = '1;
    unique case (fmt)
      FMT_IDX8: begin
        u.use_pal   = 1'b1;
        u.pal_alpha = local_en;
        u.idx       = word[7:0];
        u.key_hit   = key_en && (key[7:0] == word[7:0]);
      end
      FMT_RGB565: begin
        u.rgb     = {widen5(word[15:11]), widen6(word[10:5]), widen5(word[4:0])};
        u.key_hit = key_en && (key[15:0] == word[15:0]);
      end
      FMT_RGB555: begin
        u.rgb     = {widen5(word[14:10]), widen5(word[9:5]), widen5(word[4:0])};
        u.alpha   = switch_alpha ? '0 : '1;
        u.key_hit = key_en && (key[15:0] == word[15:0]);
      end
      FMT_RGB444: begin
        u.rgb     = {widen4(word[11:8]), widen4(word[7:4]), widen4(word[3:0])};
        u.alpha   = switch_alpha ? '0 : '1;
        u.key_hit = key_en && (key[15:0] == word[15:0]);
      end
      default: begin
        u.rgb     = word[23:0];
        u.alpha   = local_en ? word[31:24] : '1;
        u.key_hit = key_en && (key == word[23:0]);
      end
    endcase
  end
endmodule

// File: rtl/osd_alpha_calc.sv
module osd_alpha_calc
  import osd_pix_pkg::*;
(
  input  unpack_t          u,
  input  logic [CH_W-1:0]  g_alpha,
  input  logic [WORD_W-1:0] pal_entry,
  output logic [RGB_W-1:0] colour,
  output logic [CH_W-1:0]  alpha
);
  logic [CH_W-1:0] local_a;

  assign local_a = u.pal_alpha ? pal_entry[31:24] : u.alpha;
  assign colour  = u.use_pal ? pal_entry[23:0] : u.rgb;
  assign alpha   = u.key_hit ? '0 : frac_mul(local_a, g_alpha);
endmodule

// File: rtl/osd_mixer.sv
module osd_mixer
  import osd_pix_pkg::*;
#(
  parameter int CHANNELS = 3
) (
  input  logic [CHANNELS*CH_W-1:0] fg,
  input  logic [CHANNELS*CH_W-1:0] bg,
  input  logic [CH_W-1:0]          alpha,
  output logic [CHANNELS*CH_W-1:0] mix
);
  logic [CH_W-1:0] inv_alpha;
  assign inv_alpha = ~alpha;

  for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
    logic [ACC_W-1:0] acc;
    assign acc = ACC_W'(fg[c*CH_W +: CH_W]) * ACC_W'(alpha)
               + ACC_W'(bg[c*CH_W +: CH_W]) * ACC_W'(inv_alpha)
               + ACC_W'(127);
    assign mix[c*CH_W +: CH_W] = CH_W'(acc / ACC_W'(255));
  end
endmodule

// File: rtl/osd_pix_blend.sv
module osd_pix_blend
  import osd_pix_pkg::*;
#(
  parameter int PAL_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  logic [RGB_W-1:0]  in_video,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [RGB_W-1:0]  out_rgb,
  output logic [CH_W-1:0]   out_alpha,
  output logic [RGB_W-1:0]  out_mix,
  input  logic [2:0]        cfg_fmt,
  input  logic [1:0]        cfg_bpp,
  input  logic              cfg_local_en,
  input  logic              cfg_global_en,
  input  logic [CH_W-1:0]   cfg_global_alpha,
  input  logic              cfg_key_en,
  input  logic [RGB_W-1:0]  cfg_key,
  input  logic              pal_index_we,
  input  logic [PAL_AW-1:0] pal_index,
  input  logic              pal_data_we,
  input  logic [WORD_W-1:0] pal_data
);
  logic adv;

  // stage 1: unpacked pixel
  unpack_t          u_now, s1_u;
  logic             s1_vld;
  logic [CH_W-1:0]  s1_ga;
  logic [RGB_W-1:0] s1_vid;

  // stage 2: colour and effective alpha
  logic             s2_vld;
  logic [RGB_W-1:0] s2_rgb, rgb_now;
  logic [CH_W-1:0]  s2_a, a_now;
  logic [RGB_W-1:0] s2_vid;

  // stage 3: outputs
  logic             s3_vld;
  logic [RGB_W-1:0] mix_now;
  logic [WORD_W-1:0] pal_rd;

  assign adv      = !s3_vld || out_ready;
  assign in_ready = adv;

  osd_unpack u_unpack (
    .word     (in_word),
    .fmt_code (cfg_fmt),
    .bpp_code (cfg_bpp),
    .local_en (cfg_local_en),
    .key_en   (cfg_key_en),
    .key      (cfg_key),
    .u        (u_now)
  );

  osd_palette #(.AW(PAL_AW), .DW(WORD_W)) u_pal (
    .clk     (clk),
    .rst_n   (rst_n),
    .idx_we  (pal_index_we),
    .idx_in  (pal_index),
    .data_we (pal_data_we),
    .data_in (pal_data),
    .rd_addr (s1_u.idx[PAL_AW-1:0]),
    .rd_data (pal_rd)
  );

  osd_alpha_calc u_alpha (
    .u         (s1_u),
    .g_alpha   (s1_ga),
    .pal_entry (pal_rd),
    .colour    (rgb_now),
    .alpha     (a_now)
  );

  osd_mixer #(.CHANNELS(3)) u_mix (
    .fg    (s2_rgb),
    .bg    (s2_vid),
    .alpha (s2_a),
    .mix   (mix_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld <= 1'b0;
      s2_vld <= 1'b0;
      s3_vld <= 1'b0;
    end else if (adv) begin
      s1_vld <= in_valid;
      s2_vld <= s1_vld;
      s3_vld <= s2_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      s1_u      <= u_now;
      s1_ga     <= cfg_global_en ? cfg_global_alpha : '1;
      s1_vid    <= in_video;
      s2_rgb    <= rgb_now;
      s2_a      <= a_now;
      s2_vid    <= s1_vid;
      out_rgb   <= s2_rgb;
      out_alpha <= s2_a;
      out_mix   <= mix_now;
    end
  end

  assign out_valid = s3_vld;
endmodule

// File: rtl/osd_pix_blend_chk.sv
module osd_pix_blend_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [23:0] out_rgb,
  input logic [7:0]  out_alpha,
  input logic [23:0] out_mix
);
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_rgb) && $stable(out_alpha) && $stable(out_mix)); // R1
  AST_READY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R1
  AST_NO_TAKE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R1
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && out_ready) ##1 out_ready ##1 out_ready |=> out_valid); // R2
  AST_OPAQUE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_alpha == 8'hFF |-> out_mix == out_rgb); // R11
endmodule

bind osd_pix_blend osd_pix_blend_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_rgb   (out_rgb),
  .out_alpha (out_alpha),
  .out_mix   (out_mix)
);

// File: tb/osd_pix_blend_test.sv
module osd_pix_blend_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic [23:0] in_video = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [23:0] out_rgb;
  logic [7:0]  out_alpha;
  logic [23:0] out_mix;
  logic [2:0]  cfg_fmt = '0;
  logic [1:0]  cfg_bpp = 2'b11;
  logic        cfg_local_en = 1'b0;
  logic        cfg_global_en = 1'b0;
  logic [7:0]  cfg_global_alpha = '0;
  logic        cfg_key_en = 1'b0;
  logic [23:0] cfg_key = '0;
  logic        pal_index_we = 1'b0;
  logic [7:0]  pal_index = '0;
  logic        pal_data_we = 1'b0;
  logic [31:0] pal_data = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] pal_m [256];
  logic [23:0] e_rgb, e_mix;
  logic [7:0]  e_a;

  always #10 clk = ~clk;

  osd_pix_blend uut (.*);

  function automatic logic [7:0] d255(input int x);
    return 8'(x / 255);
  endfunction

  // expected results computed from the requirements
  task automatic model(input logic [31:0] w, input logic [23:0] vid);
    int fmt, la, ga;
    logic hit;
    fmt = (cfg_bpp < 2) ? 0 : (cfg_fmt > 4 ? 4 : int'(cfg_fmt));
    la = 255;
    hit = 1'b0;
    case (fmt)
      0: begin
        e_rgb = pal_m[w[7:0]][23:0];
        la = pal_m[w[7:0]][31:24];
        hit = (cfg_key[7:0] == w[7:0]);
      end
      1: begin
        e_rgb = {w[15:11], w[15:13], w[10:5], w[10:9], w[4:0], w[4:2]};
        hit = (cfg_key[15:0] == w[15:0]);
      end
      2: begin
        e_rgb = {w[14:10], w[14:12], w[9:5], w[9:7], w[4:0], w[4:2]};
        la = w[15] ? 0 : 255;
        hit = (cfg_key[15:0] == w[15:0]);
      end
      3: begin
        e_rgb = {w[11:8], w[11:8], w[7:4], w[7:4], w[3:0], w[3:0]};
        la = w[15] ? 0 : 255;
        hit = (cfg_key[15:0] == w[15:0]);
      end
      default: begin
        e_rgb = w[23:0];
        la = w[31:24];
        hit = (cfg_key == w[23:0]);
      end
    endcase
    if (!cfg_local_en) la = 255;
    ga = cfg_global_en ? int'(cfg_global_alpha) : 255;
    e_a = d255(la * ga + 127);
    if (cfg_key_en && hit) e_a = 8'd0;
    for (int c = 0; c < 3; c++) begin
      int o, v;
      o = e_rgb[c*8 +: 8];
      v = vid[c*8 +: 8];
      e_mix[c*8 +: 8] = d255(o * e_a + v * (255 - e_a) + 127);
    end
  endtask

  task automatic check(input string req, input bit ok, input string got, input string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %s expected %s", req, got, exp);
    end
  endtask

  task automatic check_out(input string req);
    check(req, out_valid && out_rgb == e_rgb && out_alpha == e_a && out_mix == e_mix,
          $sformatf("v=%0b rgb=%h a=%h mix=%h", out_valid, out_rgb, out_alpha, out_mix),
          $sformatf("v=1 rgb=%h a=%h mix=%h", e_rgb, e_a, e_mix));
  endtask

  task automatic pal_write(input logic [7:0] i, input logic [31:0] d);
    @(negedge clk);
    pal_index_we = 1'b1; pal_index = i;
    @(negedge clk);
    pal_index_we = 1'b0; pal_data_we = 1'b1; pal_data = d;
    @(negedge clk);
    pal_data_we = 1'b0;
    pal_m[i] = d;
  endtask

  task automatic beat(input logic [31:0] w, input logic [23:0] vid, input string req);
    @(negedge clk);
    in_word = w; in_video = vid; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    model(w, vid);
    check_out(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12", out_valid == 1'b0 && in_ready == 1'b1,
          $sformatf("v=%0b rdy=%0b", out_valid, in_ready), "v=0 rdy=1");
    rst_n = 1'b1;
    @(negedge clk);
    check("R12", out_valid == 1'b0 && in_ready == 1'b1,
          $sformatf("v=%0b rdy=%0b", out_valid, in_ready), "v=0 rdy=1");

    // R4 fill colour table
    for (int i = 0; i < 256; i++)
      pal_write(8'(i), {8'(i * 3), 8'(i ^ 8'hA5), 8'(i * 5 + 1), 8'(~i)});

    // R4 R7 R8 R10 indexed in 32-bit containers with padding bytes set
    cfg_fmt = 3'd0; cfg_bpp = 2'b11; cfg_local_en = 1'b1;
    cfg_global_en = 1'b1; cfg_global_alpha = 8'hC0;
    for (int i = 0; i < 256; i++)
      beat({24'hDEADBE ^ 24'(i * 77), 8'(i)}, 24'(i * 40503), "R4 R7 R8 indexed");

    // R3 8-bit containers force indexed whatever the format code
    cfg_bpp = 2'b01; cfg_local_en = 1'b0; cfg_global_en = 1'b0;
    for (int i = 0; i < 256; i++) begin
      cfg_fmt = 3'(i % 8);
      beat({24'h123456, 8'(255 - i)}, 24'(i * 911), "R3 forced indexed");
    end
    cfg_bpp = 2'b00; cfg_fmt = 3'd4;
    beat(32'hFFFFFF2A, 24'h808080, "R3 code00 indexed");

    // R5 R8 565: no per-pixel alpha even when enabled
    cfg_fmt = 3'd1; cfg_local_en = 1'b1; cfg_global_en = 1'b1; cfg_global_alpha = 8'h80;
    for (int k = 0; k < 676; k++) begin
      cfg_bpp = (k % 2 == 0) ? 2'b10 : 2'b11;
      beat({16'hA5A5 ^ 16'(k), 16'(k * 97)}, 24'(k * 3331), "R5 R7 565");
    end

    // R6 555 and 444 with switch alpha
    cfg_global_alpha = 8'hFF; cfg_bpp = 2'b10;
    for (int k = 0; k < 500; k++) begin
      cfg_fmt = 3'd2;
      cfg_local_en = (k % 3 != 0);
      beat({16'h5A5A, 16'(k * 131)}, 24'(k * 7919), "R6 555");
      cfg_fmt = 3'd3;
      beat({16'h0F0F, 16'(k * 131 + 7)}, 24'(k * 6007), "R6 444");
    end

    // R10 R11 8888 alpha by global alpha
    cfg_bpp = 2'b11; cfg_local_en = 1'b1; cfg_global_en = 1'b1;
    for (int g = 0; g < 5; g++) begin
      cfg_global_alpha = (g == 0) ? 8'd0 : (g == 1) ? 8'd1 : (g == 2) ? 8'd128 : (g == 3) ? 8'd254 : 8'd255;
      cfg_fmt = (g == 4) ? 3'd6 : 3'd4;
      for (int l = 0; l < 256; l++)
        beat({8'(l), 24'(l * 65793 + g * 12345)}, 24'(~(l * 4099)), "R10 R11 8888");
    end
    cfg_global_en = 1'b0; cfg_local_en = 1'b0;
    beat(32'h00ABCDEF, 24'h102030, "R8 R10 both off");

    // R9 colour key in each format
    cfg_key_en = 1'b1; cfg_local_en = 1'b1; cfg_global_en = 1'b1; cfg_global_alpha = 8'hF0;
    cfg_key = 24'h77F81F;
    cfg_fmt = 3'd1; cfg_bpp = 2'b11;
    beat(32'h9999F81F, 24'h445566, "R9 565 key hit");
    beat(32'h0000F81E, 24'h445566, "R9 565 key miss");
    cfg_fmt = 3'd2; beat(32'h0000F81F, 24'h112233, "R9 555 key hit");
    cfg_fmt = 3'd3; beat(32'h0000781F, 24'h112233, "R9 444 key miss");
    cfg_fmt = 3'd0; beat(32'hFFFFFF1F, 24'hABCDEF, "R9 indexed key hit");
    beat(32'h00000020, 24'hABCDEF, "R9 indexed key miss");
    cfg_fmt = 3'd4; beat(32'hFF77F81F, 24'h010203, "R9 8888 key hit");
    beat(32'hFF76F81F, 24'h010203, "R9 8888 key miss");
    cfg_key_en = 1'b0; beat(32'hFF77F81F, 24'h010203, "R9 key disabled");

    // R4 index write alone leaves entries unchanged
    cfg_fmt = 3'd0; cfg_local_en = 1'b1; cfg_global_en = 1'b0;
    @(negedge clk); pal_index_we = 1'b1; pal_index = 8'd7;
    @(negedge clk); pal_index_we = 1'b0;
    beat(32'h00000007, 24'h0F0F0F, "R4 index only");
    @(negedge clk); pal_data_we = 1'b1; pal_data = 32'h40C0FFEE;
    @(negedge clk); pal_data_we = 1'b0; pal_m[7] = 32'h40C0FFEE;
    beat(32'h00000007, 24'h0F0F0F, "R4 data write");

    // R2 latency: empty after n+1, full after n+2
    cfg_fmt = 3'd4;
    @(negedge clk); in_word = 32'h80123456; in_video = 24'h654321; in_valid = 1'b1;
    @(posedge clk); @(negedge clk); in_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R2", out_valid == 1'b0, $sformatf("v=%0b", out_valid), "v=0");
    @(posedge clk); @(negedge clk);
    model(32'h80123456, 24'h654321);
    check_out("R2 latency");

    // R1 back-pressure
    @(negedge clk);
    out_ready = 1'b0; in_word = 32'hC0A0B0C0; in_video = 24'h111111; in_valid = 1'b1;
    @(posedge clk); @(negedge clk); in_valid = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    model(32'hC0A0B0C0, 24'h111111);
    check_out("R1 first beat");
    check("R1", in_ready == 1'b0, $sformatf("rdy=%0b", in_ready), "rdy=0");
    in_word = 32'h20FEDCBA; in_video = 24'h999999; in_valid = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_out("R1 held under stall");
    check("R1", in_ready == 1'b0, $sformatf("rdy=%0b", in_ready), "rdy=0");
    out_ready = 1'b1;
    @(posedge clk); @(negedge clk); in_valid = 1'b0;
    check("R1", out_valid == 1'b0, $sformatf("v=%0b", out_valid), "v=0");
    @(posedge clk); @(posedge clk); @(negedge clk);
    model(32'h20FEDCBA, 24'h999999);
    check_out("R1 waiting beat");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule